// File: doc/BRIEF.md
# Wait-State Memory Slave for a Pipelined AHB-Lite Bus

This block is a small on-chip memory that sits on a single-master AHB-Lite bus with 32-bit address and data. The master presents address and control in one cycle (the address phase), and the slave performs the access in the following cycles (the data phase). The address phase of the next transfer overlaps the data phase of the current one. The slave registers address and control only when its own HREADY output is high. It then stretches every active data phase by a fixed number of wait states, which a parameter sets between 0 and 3.

Byte, halfword and word accesses are supported, with little-endian byte lanes selected by the two low address bits. Accesses that are misaligned or wider than the bus get the two-cycle ERROR response and leave the memory unchanged. IDLE and BUSY cycles are answered at once with OKAY and never touch the storage. The lock qualifier is accepted and has no effect.

Top module: `ahb_wait_mem`

## Requirements
- R1: While HRESETn is low, and in the first cycle after it is released, HREADY is 1 and HRESP is 0 (OKAY).
- R2: An address phase with HTRANS=00 (IDLE) or 01 (BUSY) accepted while HREADY is high is followed by a cycle with HREADY=1 and HRESP=0. The memory contents do not change.
- R3: An accepted aligned transfer with HTRANS=10 (NONSEQ) or 11 (SEQ) produces a data phase in which HREADY is 0 for exactly WAIT_STATES cycles with HRESP=0, followed by one cycle with HREADY=1 and HRESP=0.
- R4: While HREADY is 0, the values of HTRANS, HADDR, HWRITE and HSIZE are ignored. The transfer in flight completes as captured, and no extra transfer results.
- R5: A write stores bytes only on the lanes selected by HSIZE and HADDR[1:0]: HSIZE=000 writes lane HADDR[1:0], HSIZE=001 writes lanes 2*HADDR[1] and 2*HADDR[1]+1, and HSIZE=010 writes all four lanes. Lane i takes HWDATA[8i+7:8i], sampled in the cycle where HREADY returns high.
- R6: In the final (HREADY=1) cycle of a read, HRDATA carries the whole stored word at the word address. In every other cycle HRDATA is zero.
- R7: A halfword with HADDR[0]=1, a word with HADDR[1:0]≠00, or an HSIZE above 010 gets HREADY=0 with HRESP=1 for one cycle, then HREADY=1 with HRESP=1. The memory is left unchanged.
- R8: The word selected is HADDR[IDX_W+1:2] with IDX_W=log2(DEPTH_WORDS). Higher address bits are ignored, so addresses one memory size apart alias.
- R9: HMASTLOCK has no effect on timing, responses or stored data.
- R10: A transfer whose address phase falls in the completing cycle of the previous transfer is captured in that cycle, so back-to-back transfers need no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock, rising edge |
| hresetn | input | 1 | Asynchronous active-low reset |
| haddr | input | 32 | Byte address of the address phase |
| htrans | input | 2 | Transfer type: 00 idle, 01 busy, 10 nonseq, 11 seq |
| hwrite | input | 1 | 1 write, 0 read |
| hsize | input | 3 | 000 byte, 001 halfword, 010 word |
| hmastlock | input | 1 | Lock qualifier, ignored |
| hwdata | input | 32 | Write data for the transfer in its data phase |
| hrdata | output | 32 | Read data, valid in the completing cycle of a read |
| hready | output | 1 | High when the current data phase completes |
| hresp | output | 1 | 0 OKAY, 1 ERROR |

## Verification
The case hardest to reach is a master that changes address and control while the slave holds HREADY low. A well-behaved master never does this, yet the slave must ignore it. The stimulus has a noisy mode that drives random transfer types, addresses and sizes during every wait cycle, and then presents the real transfer in the ready cycle. Later reads then show that nothing extra was written. Error transfers are placed directly ahead of good ones, which exercises the capture in the second error cycle.

// File: rtl/ahb_mem_pkg.sv
package ahb_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LAST,
    ST_ERR1,
    ST_ERR2
  } dphase_e;

  localparam logic [2:0] SZ_BYTE = 3'b000;
  localparam logic [2:0] SZ_HALF = 3'b001;
  localparam logic [2:0] SZ_WORD = 3'b010;
  localparam int unsigned LANES  = 4;
endpackage

// File: rtl/ahb_mem_lanes.sv
module ahb_mem_lanes
  import ahb_mem_pkg::*;
(
  input  logic [1:0]       addr_lo,
  input  logic [2:0]       size,
  output logic [LANES-1:0] lane_en,
  output logic             bad
);
  always_comb begin
    lane_en = '0;
    bad     = 1'b0;
    case (size)
      SZ_BYTE: lane_en = 4'b0001 << addr_lo;
      SZ_HALF: begin
        bad     = addr_lo[0];
        lane_en = addr_lo[1] ? 4'b1100 : 4'b0011;
      end
      SZ_WORD: begin
        bad     = (addr_lo != 2'b00);
        lane_en = 4'b1111;
      end
      default: bad = 1'b1;
    endcase
  end

  // R5: an accepted size enables exactly 2**size byte lanes
  always_comb begin
    if (!$isunknown({addr_lo, size}) && !bad)
      p_lane_count_r5: assert ($countones(lane_en) == (1 << size));
  end
endmodule

// File: rtl/ahb_mem_array.sv
module ahb_mem_array
  import ahb_mem_pkg::*;
#(
  parameter int unsigned DEPTH_WORDS = 256,
  localparam int unsigned IDX_W = $clog2(DEPTH_WORDS)
) (
  input  logic                 clk,
  input  logic [LANES-1:0]     we,
  input  logic [IDX_W-1:0]     idx,
  input  logic [8*LANES-1:0]   wdata,
  output logic [8*LANES-1:0]   rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] bank [DEPTH_WORDS];
    always_ff @(posedge clk) begin
      if (we[l]) bank[idx] <= wdata[8*l +: 8];
    end
    assign rdata[8*l +: 8] = bank[idx];
  end
endmodule

// File: rtl/ahb_mem_ctrl.sv
module ahb_mem_ctrl
  import ahb_mem_pkg::*;
#(
  parameter int unsigned WAIT_STATES = 1,
  parameter int unsigned IDX_W       = 8,
  localparam int unsigned CNT_W = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       trans,
  input  logic             write,
  input  logic [IDX_W-1:0] idx,
  input  logic [LANES-1:0] lane_en,
  input  logic             bad,
  output logic             ready_o,
  output logic             resp_o,
  output logic [LANES-1:0] we_o,
  output logic             rd_done_o,
  output logic [IDX_W-1:0] idx_q
);
  localparam logic [CNT_W-1:0] WS_LOAD =
    CNT_W'((WAIT_STATES > 0) ? WAIT_STATES - 1 : 0);

  dphase_e          state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cap_en;
  logic             write_q;
  logic [LANES-1:0] lanes_q;

  assign ready_o = (state_q == ST_IDLE) || (state_q == ST_LAST) || (state_q == ST_ERR2);
  assign resp_o  = (state_q == ST_ERR1) || (state_q == ST_ERR2);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cap_en  = 1'b0;
    case (state_q)
      ST_WAIT: begin
        if (cnt_q == '0) state_d = ST_LAST;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_ERR1: state_d = ST_ERR2;
      default: begin
        if (trans[1]) begin
          if (bad) begin
            state_d = ST_ERR1;
          end else begin
            cap_en = 1'b1;
            if (WAIT_STATES == 0) begin
              state_d = ST_LAST;
            end else begin
              state_d = ST_WAIT;
              cnt_d   = WS_LOAD;
            end
          end
        end else begin
          state_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      lanes_q <= '0;
      idx_q   <= '0;
    end else if (cap_en) begin
      write_q <= write;
      lanes_q <= lane_en;
      idx_q   <= idx;
    end
  end

  assign we_o      = (state_q == ST_LAST && write_q) ? lanes_q : '0;
  assign rd_done_o = (state_q == ST_LAST) && !write_q;

  // Run length of OKAY wait cycles, used by the wait-bound check
  logic [2:0] lowrun_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   lowrun_q <= '0;
    else if (!ready_o && !resp_o) lowrun_q <= (lowrun_q == 3'd7) ? lowrun_q : lowrun_q + 1'b1;
    else                          lowrun_q <= '0;
  end

  p_idle_okay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !trans[1]) |=> (ready_o && !resp_o));

  p_wait_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && trans[1] && !bad) |=> (ready_o == (WAIT_STATES == 0)) && !resp_o);

  p_wait_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(lowrun_q) <= WAIT_STATES));

  p_hold_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |=> ($stable(idx_q) && $stable(write_q) && $stable(lanes_q)));

  p_write_okay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|we_o) |-> (ready_o && !resp_o));

  p_err_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && resp_o) |=> (ready_o && resp_o));
endmodule

// File: rtl/ahb_wait_mem.sv
module ahb_wait_mem
  import ahb_mem_pkg::*;
#(
  parameter int unsigned WAIT_STATES = 1,
  parameter int unsigned DEPTH_WORDS = 256
) (
  input  logic        hclk,
  input  logic        hresetn,
  input  logic [31:0] haddr,
  input  logic [1:0]  htrans,
  input  logic        hwrite,
  input  logic [2:0]  hsize,
  input  logic        hmastlock,
  input  logic [31:0] hwdata,
  output logic [31:0] hrdata,
  output logic        hready,
  output logic        hresp
);
  localparam int unsigned IDX_W = $clog2(DEPTH_WORDS);

  logic [LANES-1:0] lane_en;
  logic             bad;
  logic [LANES-1:0] we;
  logic             rd_done;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      rword;

  // Lock qualifier and upper address bits do not affect the block
  logic unused_bits;
  assign unused_bits = ^{hmastlock, haddr[31:IDX_W+2]};

  ahb_mem_lanes u_lanes (
    .addr_lo (haddr[1:0]),
    .size    (hsize),
    .lane_en (lane_en),
    .bad     (bad)
  );

  ahb_mem_ctrl #(
    .WAIT_STATES (WAIT_STATES),
    .IDX_W       (IDX_W)
  ) u_ctrl (
    .clk       (hclk),
    .rst_n     (hresetn),
    .trans     (htrans),
    .write     (hwrite),
    .idx       (haddr[IDX_W+1:2]),
    .lane_en   (lane_en),
    .bad       (bad),
    .ready_o   (hready),
    .resp_o    (hresp),
    .we_o      (we),
    .rd_done_o (rd_done),
    .idx_q     (idx_q)
  );

  ahb_mem_array #(
    .DEPTH_WORDS (DEPTH_WORDS)
  ) u_array (
    .clk   (hclk),
    .we    (we),
    .idx   (idx_q),
    .wdata (hwdata),
    .rdata (rword)
  );

  assign hrdata = rd_done ? rword : '0;

  p_rdata_quiet_r6: assert property (@(posedge hclk) disable iff (!hresetn)
    !hready |-> (hrdata == '0));
endmodule

// File: tb/ahb_wait_mem_tb_top.sv
module ahb_wait_mem_tb_top;
  localparam int WS    = 2;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        hresetn;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize;
  logic        hmastlock;
  logic [31:0] hwdata;
  logic [31:0] hrdata;
  logic        hready;
  logic        hresp;

  always #5 clk = ~clk;

  ahb_wait_mem #(.WAIT_STATES(WS), .DEPTH_WORDS(DEPTH)) dut_i (
    .hclk(clk), .hresetn(hresetn), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hmastlock(hmastlock),
    .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .hresp(hresp)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference model state
  int          m_phase = 0;  // 0 none, 1 transfer, 2 error first, 3 error second
  int          m_left  = 0;
  bit          m_wr    = 0;
  int          m_idx   = 0;
  logic [3:0]  m_lanes = '0;
  string       m_tag   = "R6";
  logic [31:0] mref [int];
  logic [31:0] pend_wdata = '0;
  string       cur_tag = "R6";
  bit          noisy = 0;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] f_lanes(input logic [1:0] a, input logic [2:0] s);
    if (s == 3'b000) return 4'b0001 << a;
    if (s == 3'b001) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic bit f_bad(input logic [1:0] a, input logic [2:0] s);
    if (s == 3'b001) return a[0];
    if (s == 3'b010) return a != 2'b00;
    return s > 3'b010;
  endfunction

  function automatic bit model_ready();
    return (m_phase == 0) || (m_phase == 1 && m_left == 0) || (m_phase == 3);
  endfunction

  function automatic int next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 8);
  endfunction

  // One bus cycle: drive, compare, advance model, move to next negedge
  task automatic step(input logic [1:0] tr, input logic [31:0] a, input bit wr,
                      input logic [2:0] sz, output bit acc);
    bit          er;
    bit          ers;
    logic [31:0] ed;
    string       rtag;
    htrans = tr; haddr = a; hwrite = wr; hsize = sz; hwdata = pend_wdata;
    er   = model_ready();
    ers  = (m_phase >= 2);
    rtag = (m_phase == 0) ? "R2" : (m_phase == 1) ? "R3" : "R7";
    chk(hready === er, rtag, {31'b0, hready}, {31'b0, er});
    chk(hresp === ers, rtag, {31'b0, hresp}, {31'b0, ers});
    ed = 32'h0;
    if (m_phase == 1 && m_left == 0 && !m_wr)
      ed = mref.exists(m_idx) ? mref[m_idx] : 32'hx;
    if (!$isunknown(ed)) chk(hrdata === ed, m_tag, hrdata, ed);
    if (m_phase == 1 && m_left > 0) m_left--;
    else if (m_phase == 2) m_phase = 3;
    else if (er) begin
      if (m_phase == 1 && m_wr) begin
        logic [31:0] w;
        w = mref.exists(m_idx) ? mref[m_idx] : 32'hx;
        for (int l = 0; l < 4; l++) if (m_lanes[l]) w[8*l +: 8] = pend_wdata[8*l +: 8];
        mref[m_idx] = w;
      end
      if (tr[1]) begin
        if (f_bad(a[1:0], sz)) m_phase = 2;
        else begin
          m_phase = 1; m_left = WS; m_wr = wr;
          m_idx = int'(a[5:2]); m_lanes = f_lanes(a[1:0], sz); m_tag = cur_tag;
        end
      end else m_phase = 0;
    end
    acc = er;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] tr, input logic [31:0] a, input bit wr,
                       input logic [2:0] sz, input logic [31:0] d);
    bit acc;
    acc = 0;
    while (!acc) begin
      if (noisy && !model_ready()) begin
        logic [31:0] r;
        r = 32'(next_rand());
        step(r[1:0], r, r[4], r[7:5], acc);
      end else step(tr, a, wr, sz, acc);
    end
    pend_wdata = d;
  endtask

  task automatic idles(input int n);
    for (int i = 0; i < n; i++) issue(2'b00, 32'h0, 1'b0, 3'b010, 32'h0);
  endtask

  initial begin
    hresetn = 1'b0; htrans = 2'b00; haddr = '0; hwrite = 1'b0;
    hsize = 3'b010; hmastlock = 1'b0; hwdata = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(hready === 1'b1, "R1", {31'b0, hready}, 32'h1);
      chk(hresp === 1'b0, "R1", {31'b0, hresp}, 32'h0);
    end
    hresetn = 1'b1;
    chk(hready === 1'b1 && hresp === 1'b0, "R1", {30'b0, hready, hresp}, 32'h2);

    // R5 R6 word writes then reads, NONSEQ then SEQ, back-to-back (R10)
    cur_tag = "R10";
    issue(2'b10, 32'h00, 1, 3'b010, 32'hA1A2A3A4);
    issue(2'b11, 32'h04, 1, 3'b010, 32'hB1B2B3B4);
    issue(2'b11, 32'h08, 1, 3'b010, 32'hC1C2C3C4);
    issue(2'b10, 32'h00, 0, 3'b010, 32'h0);
    issue(2'b11, 32'h04, 0, 3'b010, 32'h0);
    issue(2'b11, 32'h08, 0, 3'b010, 32'h0);
    idles(2);

    // R5 byte and halfword lanes
    cur_tag = "R5";
    issue(2'b10, 32'h10, 1, 3'b010, 32'h00000000);
    issue(2'b10, 32'h10, 1, 3'b000, 32'h000000_11);
    issue(2'b10, 32'h13, 1, 3'b000, 32'h44_000000);
    issue(2'b10, 32'h12, 1, 3'b000, 32'h00_33_0000);
    issue(2'b10, 32'h14, 1, 3'b010, 32'hFFFFFFFF);
    issue(2'b10, 32'h16, 1, 3'b001, 32'h5566_0000);
    issue(2'b10, 32'h14, 1, 3'b001, 32'h0000_7788);
    issue(2'b10, 32'h10, 0, 3'b010, 32'h0);
    issue(2'b10, 32'h14, 0, 3'b000, 32'h0);

    // R2 IDLE and BUSY interleaved with a read
    cur_tag = "R2";
    issue(2'b01, 32'h00, 1, 3'b010, 32'hDEADBEEF);
    issue(2'b00, 32'h04, 1, 3'b010, 32'hDEADBEEF);
    issue(2'b01, 32'h08, 1, 3'b010, 32'hDEADBEEF);
    issue(2'b10, 32'h00, 0, 3'b010, 32'h0);
    issue(2'b10, 32'h04, 0, 3'b010, 32'h0);

    // R7 misaligned and oversize, then reads show no change
    cur_tag = "R7";
    issue(2'b10, 32'h01, 1, 3'b001, 32'h99999999);
    issue(2'b10, 32'h02, 1, 3'b010, 32'h88888888);
    issue(2'b10, 32'h04, 1, 3'b011, 32'h77777777);
    issue(2'b11, 32'h08, 0, 3'b010, 32'h0);
    issue(2'b10, 32'h00, 0, 3'b010, 32'h0);
    issue(2'b10, 32'h04, 0, 3'b010, 32'h0);

    // R8 aliasing one memory size up
    cur_tag = "R8";
    issue(2'b10, 32'h0000_0040 + 32'h8, 1, 3'b010, 32'h0BADF00D);
    issue(2'b10, 32'hFFFF_FFC8, 0, 3'b010, 32'h0);
    issue(2'b10, 32'h08, 0, 3'b010, 32'h0);

    // R4 random control during every wait cycle
    cur_tag = "R4";
    noisy = 1;
    issue(2'b10, 32'h20, 1, 3'b010, 32'h12345678);
    issue(2'b11, 32'h24, 1, 3'b010, 32'h9ABCDEF0);
    issue(2'b10, 32'h20, 0, 3'b010, 32'h0);
    issue(2'b10, 32'h24, 0, 3'b010, 32'h0);
    issue(2'b10, 32'h10, 0, 3'b010, 32'h0);
    issue(2'b10, 32'h00, 0, 3'b010, 32'h0);
    noisy = 0;

    // R9 lock qualifier toggled
    cur_tag = "R9";
    hmastlock = 1'b1;
    issue(2'b10, 32'h30, 1, 3'b010, 32'hCAFEF00D);
    hmastlock = 1'b0;
    issue(2'b10, 32'h30, 1, 3'b000, 32'h000000EE);
    hmastlock = 1'b1;
    issue(2'b10, 32'h30, 0, 3'b010, 32'h0);
    hmastlock = 1'b0;
    idles(3);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule